// File: doc/BRIEF.md
# Compare and Rollover Timer

This block is a free-running up-counter with one output-compare channel and wrap detection, driven through a small word-addressed register file. While the enable bit is set, a prescale divider lets the counter step once every (prescale + 1) clocks. The counter raises a compare flag when it takes the programmed compare value, and a rollover flag when it wraps from all ones back to zero. Each flag has its own interrupt enable. Software clears the flags by writing ones.

Software loads the prescale divider and the enables, then sets the enable bit. After that, and only then, it programs the compare value. It then services the single interrupt line. Clearing the enable bit freezes the counter and masks the interrupt, but keeps the flags, so software can still read them.

Top module: `cmp_roll_timer`

## Requirements
- R1: After reset, every register word reads zero and `irq` is low.
- R2: While enabled, the count (word 9, zero-extended, read-only) increases by one exactly once every (prescale + 1) clocks. The prescale divider is word 1.
- R3: In the clock edge at which the count takes the compare value (word 4), status bit 0, the compare flag, becomes 1.
- R4: In the clock edge at which the count wraps from all ones to zero, status bit 5, the rollover flag, becomes 1.
- R5: Writing status (word 2) clears each flag whose bit (0 or 5) is 1 in the written data. A flag whose bit is written as 0 is unchanged.
- R6: If hardware sets a flag in the same edge as a write-one-to-clear of that flag, the flag ends set.
- R7: `irq` is 1 exactly when control bit 0 is 1 and some flag is set whose interrupt-enable bit is set. The interrupt-enable register is word 3, with bit 0 for compare and bit 5 for rollover.
- R8: A write to the compare value takes effect only if control bit 0 was already 1. Otherwise the write is dropped.
- R9: While control bit 0 is 0, the count holds and no flag is newly set. Flags that are already set stay readable.
- R10: Reads of word offsets other than 0, 1, 2, 3, 4 and 9 return zero. Writes to those offsets, and writes to word 9, change nothing.
- R11: Control (word 0) reads back bit 0 only. Prescale (word 1) reads back in full. Interrupt enable (word 3) reads back bits 0 and 5 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model of the count, the flags and the registers runs alongside the design. The counter is made eight bits wide so that wraps come quickly. The timer is run with prescale values 3 and 0: the slow setting shows whether steps are spaced by prescale + 1, and the fast one reaches the wrap and lets a clear land on the exact edge of a compare hit. The enable mask is switched between the compare bit alone and both bits, which shows whether each flag is gated by its own enable bit. Writes made while the timer is disabled, and writes to unused and read-only words, check that those writes are dropped.

// File: rtl/cmp_roll_timer.sv
module cmp_roll_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PRE  = AW'(1);
  localparam logic [AW-1:0] A_STS  = AW'(2);
  localparam logic [AW-1:0] A_IE   = AW'(3);
  localparam logic [AW-1:0] A_CMP  = AW'(4);
  localparam logic [AW-1:0] A_CNT  = AW'(9);
  localparam int B_CMP  = 0;
  localparam int B_ROLL = 5;

  logic             en_q;
  logic [PRE_W-1:0] pre_q, div_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             sts_cmp, sts_roll, ie_cmp, ie_roll;

  logic tick, hit_cmp, hit_roll, wr_ctrl, wr_pre, wr_sts, wr_ie, wr_cmp;
  logic [CNT_W-1:0] cnt_nxt;

  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_pre  = bus_we && bus_addr == A_PRE;
  assign wr_sts  = bus_we && bus_addr == A_STS;
  assign wr_ie   = bus_we && bus_addr == A_IE;
  assign wr_cmp  = bus_we && bus_addr == A_CMP && en_q;

  assign tick     = en_q && (div_q >= pre_q);
  assign cnt_nxt  = cnt_q + 1'b1;
  assign hit_cmp  = tick && cnt_nxt == cmp_q;
  assign hit_roll = tick && &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pre_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      cmp_q <= '0;
      ie_cmp  <= 1'b0;
      ie_roll <= 1'b0;
      sts_cmp  <= 1'b0;
      sts_roll <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[0];
      if (wr_pre)  pre_q <= bus_wdata[PRE_W-1:0];
      if (wr_cmp)  cmp_q <= bus_wdata[CNT_W-1:0];
      if (wr_ie) begin
        ie_cmp  <= bus_wdata[B_CMP];
        ie_roll <= bus_wdata[B_ROLL];
      end
      if (!en_q)     div_q <= '0;
      else if (tick) div_q <= '0;
      else           div_q <= div_q + 1'b1;
      if (tick) cnt_q <= cnt_nxt;
      sts_cmp  <= hit_cmp  | (sts_cmp  & ~(wr_sts & bus_wdata[B_CMP]));
      sts_roll <= hit_roll | (sts_roll & ~(wr_sts & bus_wdata[B_ROLL]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = en_q;
      A_PRE:  bus_rdata[PRE_W-1:0] = pre_q;
      A_STS:  begin bus_rdata[B_CMP] = sts_cmp; bus_rdata[B_ROLL] = sts_roll; end
      A_IE:   begin bus_rdata[B_CMP] = ie_cmp;  bus_rdata[B_ROLL] = ie_roll;  end
      A_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
      A_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = en_q & ((sts_cmp & ie_cmp) | (sts_roll & ie_roll));
endmodule

module cmp_roll_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             sts_cmp,
  input logic             sts_roll
);
  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ($stable(cnt_q) && !$rose(sts_cmp) && !$rose(sts_roll)));
  // R8
  cmp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cmp_q));
  // R3
  cmp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_cmp) |-> cnt_q == $past(cmp_q));
  // R4
  roll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_roll) |-> cnt_q == '0);
endmodule

bind cmp_roll_timer cmp_roll_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .cnt_q(cnt_q), .cmp_q(cmp_q),
  .sts_cmp(sts_cmp), .sts_roll(sts_roll)
);

// File: tb/test_cmp_roll_timer.sv
module test_cmp_roll_timer;
  localparam int PERIOD = 10;
  localparam int CW = 8;
  localparam int CMASK = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_ok = 0, cyc = 0;
  bit live = 0;

  int m_en = 0, m_pre = 0, m_since = 0, m_cnt = 0, m_cmp = 0, m_ie = 0, m_sts = 0;

  cmp_roll_timer #(.CNT_W(CW)) i_cmp_roll_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (ok) n_ok++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  function automatic string tag(input int a);
    case (a)
      9: return "R2";
      2: return "R5";
      4: return "R8";
      0, 1, 3: return "R11";
      default: return "R10";
    endcase
  endfunction

  function automatic int m_read(input int a);
    case (a)
      0: return m_en;
      1: return m_pre;
      2: return m_sts;
      3: return m_ie;
      4: return m_cmp;
      9: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pre = 0; m_since = 0; m_cnt = 0; m_cmp = 0; m_ie = 0; m_sts = 0;
    end else begin
      automatic bit tk = 0;
      automatic int set = 0;
      automatic int old_en = m_en;
      if (m_en != 0) begin
        if (m_since >= m_pre) begin tk = 1; m_since = 0; end
        else m_since++;
      end else m_since = 0;
      if (tk) begin
        if (m_cnt == CMASK) set |= 32'h20;
        m_cnt = (m_cnt + 1) & CMASK;
        if (m_cnt == m_cmp) set |= 1;
      end
      if (we) begin
        case (addr)
          0: m_en = wdata[0];
          1: m_pre = wdata;
          2: m_sts = m_sts & ~(wdata & 32'h21);
          3: m_ie = wdata & 32'h21;
          4: if (old_en != 0) m_cmp = wdata & CMASK;
          default: ;
        endcase
      end
      m_sts |= set;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      automatic int exp_irq = (m_en != 0 && (m_sts & m_ie) != 0) ? 1 : 0;
      check(rdata == 32'(m_read(addr)), tag(addr), rdata, m_read(addr));
      check(irq == exp_irq[0], "R7", irq, exp_irq);
    end
    if (cyc > 20000) begin
      check(0, "watchdog", cyc, 20000);
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step();
    we = 1'b1; addr = 4'(a); wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    step();
    addr = 4'(a);
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    logic [31:0] v, v2;
    int lim;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    rst_n = 1'b1;
    live = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      check(v == 0, "R1", v, 0);
    end
    check(irq == 1'b0, "R1", irq, 0);
    // R11 readback
    wr(1, 32'd3);
    rd(1, v); check(v == 3, "R11", v, 3);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); check(v == 32'h21, "R11", v, 32'h21);
    wr(0, 32'hFFFF_FFFE);
    rd(0, v); check(v == 0, "R11", v, 0);
    // R8 compare write while disabled is dropped
    wr(4, 32'h10);
    rd(4, v); check(v == 0, "R8", v, 0);
    // R10 unused and read-only words
    wr(9, 32'h55);
    rd(9, v); check(v == 0, "R10", v, 0);
    wr(7, 32'hFFFF_FFFF);
    rd(7, v); check(v == 0, "R10", v, 0);
    // enable with prescale 3, then program compare
    wr(0, 32'd1);
    wr(4, 32'h10);
    rd(4, v); check(v == 32'h10, "R8", v, 32'h10);
    // R2 spacing: eight edges give two steps
    rd(9, v);
    for (int i = 0; i < 8; i++) rd(9, v2);
    check(v2 - v == 2, "R2", v2 - v, 2);
    // R3 compare flag
    lim = 0;
    do begin rd(9, v); lim++; end while (v != 32'h10 && lim < 200);
    check(v == 32'h10, "R3", v, 32'h10);
    rd(2, v); check(v == 32'h01, "R3", v, 1);
    check(irq == 1'b1, "R7", irq, 1);
    // R7 enable mask selects the flag
    wr(3, 32'h20);
    rd(2, v); check(irq == 1'b0, "R7", irq, 0);
    wr(3, 32'h21);
    rd(2, v); check(irq == 1'b1, "R7", irq, 1);
    // R5 write-one-to-clear
    wr(2, 32'h20);
    rd(2, v); check(v == 32'h01, "R5", v, 1);
    // R9 disable freezes count and masks irq, flag kept
    wr(0, 32'd0);
    rd(2, v); check(v == 32'h01, "R9", v, 1);
    check(irq == 1'b0, "R9", irq, 0);
    rd(9, v);
    repeat (20) step();
    rd(9, v2); check(v2 == v, "R9", v2, v);
    wr(2, 32'h01);
    rd(2, v); check(v == 0, "R5", v, 0);
    // R4 rollover at prescale 0
    wr(1, 32'd0);
    wr(0, 32'd1);
    lim = 0;
    do begin rd(2, v); lim++; end while (v[5] == 1'b0 && lim < 400);
    check(v[5] == 1'b1, "R4", v, 32'h20);
    rd(9, v2); check(v2 == 1, "R4", v2, 1);
    // R6 set wins over a clear in the same edge
    rd(9, v);
    wr(4, (v + 32'd30) & CMASK);
    rd(4, v2);
    lim = 0;
    do begin rd(9, v); lim++; end while (v != ((v2 - 2) & CMASK) && lim < 400);
    wr(2, 32'h01);
    rd(2, v); check(v[0] == 1'b1, "R6", v, 1);
    wr(2, 32'h21);
    rd(2, v); check(v == 0, "R5", v, 0);
    repeat (4) step();
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule